// File: doc/BRIEF.md
# SDRAM Mode Register and Read-Latency Pipeline

This block is the device-side timing core of a single-data-rate SDRAM. A mode-load command writes a set of fields taken from the address bus. The fields give the burst length, the column ordering, the read latency and the operating mode. Once a legal mode is held, each READ or WRITE command starts a burst. The burst walks a computed sequence of columns over a memory-array port, one column per clock.

For writes, the word on the data input goes straight to the array in the same cycle. For reads, the word fetched from the array passes through a register pipeline. It reaches the DQ output after the programmed latency. The DQ drive enable rises one clock before the first word and falls one clock after the last word. When a mode load is illegal it is refused and flagged. A READ or WRITE that arrives before any legal mode has been loaded is also refused and flagged.

Top module: `sdr_mode_lat_ctl`

## Requirements
- R1: A mode load (cmd_i = 01) takes its fields from addr_i. Burst-length code [2:0] gives lengths 1/2/4/8 for 000/001/010/011. Bit [3] selects the order (0 sequential, 1 interleaved). Latency code [6:4] is 010 for 2 clocks or 011 for 3 clocks. Mode bits [8:7] must be 00. A legal load clears mode_err_o and takes effect for commands from the next clock on.
- R2: A mode load that has any other burst-length code, any other latency code, or non-zero bits [8:7] raises mode_err_o from the following clock. It leaves the previously held mode unchanged.
- R3: A READ (cmd_i = 10) or WRITE (cmd_i = 11) issued before any legal mode load causes no array access and no DQ drive. It sets cmd_err_o, which stays set until reset.
- R4: In sequential order, column k of a burst starting at column s is s with its low log2(BL) bits replaced by (s + k) mod BL.
- R5: In interleaved order, column k is s with its low log2(BL) bits replaced by (s XOR k) on those bits.
- R6: The programmed burst length applies to both reads and writes. For a command registered on edge n, arr_rd_o (read) or arr_we_o (write) is high in the BL cycles that follow edges n through n+BL-1, and low after that.
- R7: With latency m, the word fetched in the cycle after edge n+k appears on dq_o in the cycle after edge n+m+k.
- R8: dq_oe_o rises in the cycle after edge n+m-1. It stays high through the last data word and is low from the next cycle. dq_o is zero whenever no read word is due.
- R9: During a write burst, arr_wdata_o carries dq_i of the same cycle, and arr_col_o follows the R4/R5 order.
- R10: A READ or WRITE that arrives during a burst cuts it off and starts the new burst on the next cycle. Read words already fetched still emerge at their latency.
- R11: After reset all outputs are zero and no mode is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_i | input | 2 | Command: 00 NOP, 01 mode load, 10 READ, 11 WRITE |
| addr_i | input | ADDR_W | Mode fields on a mode load, start column on READ/WRITE |
| dq_i | input | DQ_W | Write data |
| dq_o | output | DQ_W | Read data |
| dq_oe_o | output | 1 | DQ drive enable |
| arr_col_o | output | COL_W | Array column address |
| arr_rd_o | output | 1 | Array read strobe |
| arr_we_o | output | 1 | Array write strobe |
| arr_wdata_o | output | DQ_W | Array write data |
| arr_rdata_i | input | DQ_W | Array read data, same cycle as the column |
| mode_err_o | output | 1 | Last mode load was refused |
| cmd_err_o | output | 1 | Access attempted before a legal mode load |

## Verification
A write burst can touch the array in the same cycle that read words from the previous burst are still leaving the latency pipeline. The bench provokes this with a two-word read at latency 3 followed two clocks later by a WRITE. It then checks, cycle by cycle, that arr_we_o, arr_col_o and arr_wdata_o follow the write while dq_o and dq_oe_o still deliver the two read words at their computed cycles. A second overlap is a READ that cuts off a running read burst. Here the bench checks that the output words run on without a gap and switch to the new column stream exactly two fetches in.

// File: rtl/sdr_ctl_pkg.sv
package sdr_ctl_pkg;
  typedef enum logic [1:0] {
    CMD_NOP  = 2'b00,
    CMD_LOAD = 2'b01,
    CMD_RD   = 2'b10,
    CMD_WR   = 2'b11
  } sdr_cmd_e;

  typedef struct packed {
    logic [1:0] bl_code;
    logic       bt_il;
    logic [1:0] lat;
  } mode_t;

  localparam int unsigned MODE_W  = 9;
  localparam int unsigned LAT_MAX = 3;

  function automatic logic mode_ok(logic [MODE_W-1:0] f);
    return !f[2] && (f[6:4] == 3'd2 || f[6:4] == 3'd3) && (f[8:7] == 2'b00);
  endfunction

  function automatic mode_t mode_dec(logic [MODE_W-1:0] f);
    mode_t m;
    m.bl_code = f[1:0];
    m.bt_il   = f[3];
    m.lat     = f[5:4];
    return m;
  endfunction
endpackage

// File: rtl/sdr_mode_reg.sv
module sdr_mode_reg
  import sdr_ctl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  sdr_cmd_e          cmd_i,
  input  logic [MODE_W-1:0] field_i,
  output mode_t             mode_o,
  output logic              loaded_o,
  output logic              mode_err_o,
  output logic              cmd_err_o
);
  mode_t mode_q;
  logic  loaded_q, mode_err_q, cmd_err_q;
  logic  acc_cmd;

  assign acc_cmd = (cmd_i == CMD_RD) || (cmd_i == CMD_WR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q     <= '{bl_code: 2'd0, bt_il: 1'b0, lat: 2'd2};
      loaded_q   <= 1'b0;
      mode_err_q <= 1'b0;
      cmd_err_q  <= 1'b0;
    end else begin
      if (cmd_i == CMD_LOAD) begin
        if (mode_ok(field_i)) begin
          mode_q     <= mode_dec(field_i);
          loaded_q   <= 1'b1;
          mode_err_q <= 1'b0;
        end else begin
          mode_err_q <= 1'b1;
        end
      end
      if (acc_cmd && !loaded_q) cmd_err_q <= 1'b1;
    end
  end

  assign mode_o     = mode_q;
  assign loaded_o   = loaded_q;
  assign mode_err_o = mode_err_q;
  assign cmd_err_o  = cmd_err_q;
endmodule

// File: rtl/sdr_burst_seq.sv
module sdr_burst_seq #(
  parameter int unsigned COL_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             start_wr_i,
  input  logic [COL_W-1:0] col_i,
  input  logic [1:0]       bl_code_i,
  input  logic             bt_il_i,
  output logic [COL_W-1:0] col_o,
  output logic             rd_o,
  output logic             wr_o
);
  localparam int unsigned KW = 3;

  logic             act_q, wr_q, il_q;
  logic [KW-1:0]    k_q, mask_q, mask_d, low;
  logic [COL_W-1:0] base_q;

  always_comb begin
    unique case (bl_code_i)
      2'd0:    mask_d = 3'b000;
      2'd1:    mask_d = 3'b001;
      2'd2:    mask_d = 3'b011;
      default: mask_d = 3'b111;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      wr_q   <= 1'b0;
      il_q   <= 1'b0;
      k_q    <= '0;
      mask_q <= '0;
      base_q <= '0;
    end else if (start_i) begin
      act_q  <= 1'b1;
      wr_q   <= start_wr_i;
      il_q   <= bt_il_i;
      k_q    <= '0;
      mask_q <= mask_d;
      base_q <= col_i;
    end else if (act_q) begin
      if (k_q == mask_q) act_q <= 1'b0;
      else               k_q   <= k_q + 1'b1;
    end
  end

  // low bits wrap inside the burst-aligned block
  assign low   = il_q ? (base_q[KW-1:0] ^ k_q) : (base_q[KW-1:0] + k_q);
  assign col_o = {base_q[COL_W-1:KW], (base_q[KW-1:0] & ~mask_q) | (low & mask_q)};
  assign rd_o  = act_q & ~wr_q;
  assign wr_o  = act_q &  wr_q;
endmodule

// File: rtl/sdr_rd_pipe.sv
module sdr_rd_pipe #(
  parameter int unsigned DQ_W    = 16,
  parameter int unsigned LAT_MAX = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            vld_i,
  input  logic [DQ_W-1:0] data_i,
  input  logic [1:0]      lat_i,
  output logic [DQ_W-1:0] dq_o,
  output logic            oe_o
);
  logic [LAT_MAX-1:0] vld_q;
  logic [DQ_W-1:0]    data_q [LAT_MAX];
  logic [1:0]         tap, lead;

  for (genvar g = 0; g < LAT_MAX; g++) begin : g_stg
    if (g == 0) begin : g_head
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          vld_q[0]  <= 1'b0;
          data_q[0] <= '0;
        end else begin
          vld_q[0]  <= vld_i;
          data_q[0] <= data_i;
        end
      end
    end else begin : g_body
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          vld_q[g]  <= 1'b0;
          data_q[g] <= '0;
        end else begin
          vld_q[g]  <= vld_q[g-1];
          data_q[g] <= data_q[g-1];
        end
      end
    end
  end

  assign tap  = lat_i - 2'd1;
  assign lead = lat_i - 2'd2;

  // enable leads the data tap by one stage
  always_comb begin
    dq_o = '0;
    oe_o = 1'b0;
    for (int i = 0; i < LAT_MAX; i++) begin
      if (2'(i) == tap && vld_q[i]) dq_o = data_q[i];
      if ((2'(i) == tap || 2'(i) == lead) && vld_q[i]) oe_o = 1'b1;
    end
  end
endmodule

// File: rtl/sdr_mode_lat_ctl.sv
module sdr_mode_lat_ctl
  import sdr_ctl_pkg::*;
#(
  parameter int unsigned COL_W  = 8,
  parameter int unsigned DQ_W   = 16,
  parameter int unsigned ADDR_W = (COL_W > MODE_W) ? COL_W : MODE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        cmd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DQ_W-1:0]   dq_i,
  output logic [DQ_W-1:0]   dq_o,
  output logic              dq_oe_o,
  output logic [COL_W-1:0]  arr_col_o,
  output logic              arr_rd_o,
  output logic              arr_we_o,
  output logic [DQ_W-1:0]   arr_wdata_o,
  input  logic [DQ_W-1:0]   arr_rdata_i,
  output logic              mode_err_o,
  output logic              cmd_err_o
);
  sdr_cmd_e cmd;
  mode_t    mode;
  logic     loaded, start, rd, wr;

  assign cmd   = sdr_cmd_e'(cmd_i);
  assign start = loaded && (cmd == CMD_RD || cmd == CMD_WR);

  sdr_mode_reg u_mode (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_i      (cmd),
    .field_i    (addr_i[MODE_W-1:0]),
    .mode_o     (mode),
    .loaded_o   (loaded),
    .mode_err_o (mode_err_o),
    .cmd_err_o  (cmd_err_o)
  );

  sdr_burst_seq #(.COL_W(COL_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .start_wr_i (cmd == CMD_WR),
    .col_i      (addr_i[COL_W-1:0]),
    .bl_code_i  (mode.bl_code),
    .bt_il_i    (mode.bt_il),
    .col_o      (arr_col_o),
    .rd_o       (rd),
    .wr_o       (wr)
  );

  sdr_rd_pipe #(.DQ_W(DQ_W), .LAT_MAX(LAT_MAX)) u_pipe (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .vld_i  (rd),
    .data_i (arr_rdata_i),
    .lat_i  (mode.lat),
    .dq_o   (dq_o),
    .oe_o   (dq_oe_o)
  );

  assign arr_rd_o    = rd;
  assign arr_we_o    = wr;
  assign arr_wdata_o = wr ? dq_i : '0;
endmodule

// File: rtl/sdr_mode_lat_chk.sv
module sdr_mode_lat_chk #(
  parameter int unsigned DQ_W = 16
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [1:0]      cmd_i,
  input logic [8:0]      mode_f,
  input logic [DQ_W-1:0] dq_o,
  input logic            dq_oe_o,
  input logic            arr_rd_o,
  input logic            arr_we_o,
  input logic [DQ_W-1:0] arr_rdata_i,
  input logic            mode_err_o,
  input logic            cmd_err_o
);
  logic       seen_q;
  logic [1:0] lat_q;
  logic       f_ok;

  assign f_ok = !mode_f[2] && (mode_f[6:4] == 3'd2 || mode_f[6:4] == 3'd3) && mode_f[8:7] == 2'b00;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 1'b0;
      lat_q  <= 2'd2;
    end else if (cmd_i == 2'b01 && f_ok) begin
      seen_q <= 1'b1;
      lat_q  <= mode_f[5:4];
    end
  end

  a_r2_reserved_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == 2'b01 && mode_f[8:7] != 2'b00) |=> mode_err_o);

  a_r3_no_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seen_q |-> (!arr_rd_o && !arr_we_o));

  a_r3_err_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i[1] && !seen_q) |=> cmd_err_o);

  a_r7_lat2_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lat_q == 2'd2 && arr_rd_o && cmd_i != 2'b01) |=> ##1 (dq_o == $past(arr_rdata_i, 2)));

  a_r8_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dq_oe_o |-> (dq_o == '0));

  a_r8_lead_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dq_oe_o) |-> (dq_o == '0));

  a_r8_oe_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dq_oe_o) |=> dq_oe_o);
endmodule

bind sdr_mode_lat_ctl sdr_mode_lat_chk #(.DQ_W(DQ_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_i       (cmd_i),
  .mode_f      (addr_i[8:0]),
  .dq_o        (dq_o),
  .dq_oe_o     (dq_oe_o),
  .arr_rd_o    (arr_rd_o),
  .arr_we_o    (arr_we_o),
  .arr_rdata_i (arr_rdata_i),
  .mode_err_o  (mode_err_o),
  .cmd_err_o   (cmd_err_o)
);

// File: tb/sdr_mode_lat_ctl_tb_top.sv
`timescale 1ns/1ps
module sdr_mode_lat_ctl_tb_top;
  localparam int COL_W = 8;
  localparam int DQ_W  = 16;
  localparam logic [1:0] NOP = 2'b00, LOAD = 2'b01, RD = 2'b10, WR = 2'b11;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [1:0]       cmd = NOP;
  logic [8:0]       addr = '0;
  logic [DQ_W-1:0]  dq_i = '0;
  logic [DQ_W-1:0]  dq_o, arr_wdata, arr_rdata;
  logic [COL_W-1:0] arr_col;
  logic             dq_oe, arr_rd, arr_we, mode_err, cmd_err;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  assign arr_rdata = {~arr_col, arr_col};

  sdr_mode_lat_ctl #(.COL_W(COL_W), .DQ_W(DQ_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cmd_i(cmd), .addr_i(addr), .dq_i(dq_i),
    .dq_o(dq_o), .dq_oe_o(dq_oe), .arr_col_o(arr_col), .arr_rd_o(arr_rd),
    .arr_we_o(arr_we), .arr_wdata_o(arr_wdata), .arr_rdata_i(arr_rdata),
    .mode_err_o(mode_err), .cmd_err_o(cmd_err)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic issue(input logic [1:0] c, input logic [8:0] a);
    @(negedge clk);
    cmd  = c;
    addr = a;
  endtask

  function automatic logic [8:0] mw(int bl, int bt, int cl, int op);
    return {op[1:0], cl[2:0], bt[0], bl[2:0]};
  endfunction

  function automatic logic [7:0] seq_col(logic [7:0] s, int code, int il, int k);
    logic [7:0] m, lo;
    m  = 8'((1 << code) - 1);
    lo = il ? (s ^ 8'(k)) : (s + 8'(k));
    return (s & ~m) | (lo & m);
  endfunction

  function automatic logic [15:0] word(logic [7:0] c);
    return {~c, c};
  endfunction

  // read burst sweep body: READ registered on edge n, c counts cycles after it
  task automatic read_burst(int code, int il, int cl, logic [7:0] s);
    int len;
    len = 1 << code;
    issue(LOAD, mw(code, il, cl, 0));
    issue(RD, {1'b0, s});
    @(negedge clk);
    cmd = NOP;
    for (int c = 0; c < cl + len + 2; c++) begin
      #1;
      check("R6 read strobe", 32'(arr_rd), 32'(c < len));
      if (c < len)
        check(il ? "R5 interleaved col" : "R4 sequential col", 32'(arr_col), 32'(seq_col(s, code, il, c)));
      check("R8 drive enable", 32'(dq_oe), 32'((c >= cl - 1) && (c <= cl + len - 1)));
      check("R7 read data", 32'(dq_o),
            (c >= cl && c < cl + len) ? 32'(word(seq_col(s, code, il, c - cl))) : 32'd0);
      @(negedge clk);
    end
  endtask

  task automatic write_burst(int code, int il, logic [7:0] s);
    int len;
    len = 1 << code;
    issue(LOAD, mw(code, il, 2, 0));
    issue(WR, {1'b0, s});
    @(negedge clk);
    cmd = NOP;
    for (int c = 0; c <= len; c++) begin
      dq_i = 16'h5A00 + 16'(c * 3);
      #1;
      check("R6 write strobe", 32'(arr_we), 32'(c < len));
      if (c < len) begin
        check("R9 write col", 32'(arr_col), 32'(seq_col(s, code, il, c)));
        check("R9 write data", 32'(arr_wdata), 32'(dq_i));
      end
      check("R6 no read on write", 32'(arr_rd), 32'd0);
      check("R8 no drive on write", 32'(dq_oe), 32'd0);
      @(negedge clk);
    end
    dq_i = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R11 reset state
    check("R11 dq_oe", 32'(dq_oe), 0);
    check("R11 dq", 32'(dq_o), 0);
    check("R11 rd", 32'(arr_rd), 0);
    check("R11 we", 32'(arr_we), 0);
    check("R11 mode_err", 32'(mode_err), 0);
    check("R11 cmd_err", 32'(cmd_err), 0);

    // R3 access before any legal load
    issue(RD, 9'h003);
    issue(WR, 9'h005);
    @(negedge clk);
    cmd = NOP;
    for (int c = 0; c < 6; c++) begin
      #1;
      check("R3 no read", 32'(arr_rd), 0);
      check("R3 no write", 32'(arr_we), 0);
      check("R3 no drive", 32'(dq_oe), 0);
      @(negedge clk);
    end
    check("R3 cmd_err set", 32'(cmd_err), 1);

    // R1/R2 legal then illegal loads
    issue(LOAD, mw(1, 0, 2, 0));
    @(negedge clk); cmd = NOP; #1;
    check("R1 legal clears", 32'(mode_err), 0);
    issue(LOAD, mw(4, 0, 2, 0));
    @(negedge clk); cmd = NOP; #1;
    check("R2 bad burst code", 32'(mode_err), 1);
    issue(LOAD, mw(1, 0, 2, 0));
    @(negedge clk); cmd = NOP; #1;
    check("R1 legal clears again", 32'(mode_err), 0);
    issue(LOAD, mw(3, 1, 1, 0));
    @(negedge clk); cmd = NOP; #1;
    check("R2 bad latency code", 32'(mode_err), 1);
    issue(LOAD, mw(3, 1, 3, 1));
    @(negedge clk); cmd = NOP; #1;
    check("R2 reserved mode bits", 32'(mode_err), 1);
    // held mode still BL2 sequential latency 2
    issue(RD, 9'h007);
    @(negedge clk);
    cmd = NOP;
    for (int c = 0; c < 5; c++) begin
      #1;
      check("R2 mode kept: strobe", 32'(arr_rd), 32'(c < 2));
      check("R2 mode kept: enable", 32'(dq_oe), 32'(c >= 1 && c <= 3));
      if (c < 2) check("R2 mode kept: col", 32'(arr_col), 32'(c == 0 ? 8'h07 : 8'h06));
      @(negedge clk);
    end
    check("R3 cmd_err sticky", 32'(cmd_err), 1);

    // R4..R8 read sweep
    for (int code = 0; code < 4; code++)
      for (int il = 0; il < 2; il++)
        for (int cl = 2; cl < 4; cl++)
          for (int s = 0; s < 12; s++)
            read_burst(code, il, cl, (s < 8) ? 8'(s) : 8'(s * 37));

    // R6/R9 write sweep
    for (int code = 0; code < 4; code++)
      for (int il = 0; il < 2; il++)
        for (int s = 0; s < 6; s++)
          write_burst(code, il, 8'(s * 45 + 3));

    // R10 READ cuts a running read burst (BL8, sequential, latency 2)
    issue(LOAD, mw(3, 0, 2, 0));
    for (int c = -1; c < 14; c++) begin
      logic [7:0] f;
      @(negedge clk);
      cmd  = (c == -1 || c == 1) ? RD : NOP;
      addr = (c == 1) ? 9'h020 : 9'h000;
      if (c >= 0) begin
        #1;
        check("R10 strobe", 32'(arr_rd), 32'(c <= 9));
        if (c <= 9) begin
          f = (c < 2) ? 8'(c) : 8'(8'h20 + c - 2);
          check("R10 col", 32'(arr_col), 32'(f));
        end
        check("R10 enable", 32'(dq_oe), 32'(c >= 1 && c <= 11));
        if (c >= 2 && c <= 11) begin
          f = (c - 2 < 2) ? 8'(c - 2) : 8'(8'h20 + c - 4);
          check("R10 data", 32'(dq_o), 32'(word(f)));
        end else begin
          check("R10 data idle", 32'(dq_o), 0);
        end
      end
    end

    // write overlapping read drain (BL2, latency 3)
    issue(LOAD, mw(1, 0, 3, 0));
    for (int c = -1; c < 7; c++) begin
      @(negedge clk);
      cmd  = (c == -1) ? RD : (c == 1) ? WR : NOP;
      addr = (c == -1) ? 9'h040 : 9'h080;
      dq_i = 16'hA000 + 16'(c + 1);
      if (c >= 0) begin
        #1;
        check("R6 overlap rd", 32'(arr_rd), 32'(c <= 1));
        check("R6 overlap we", 32'(arr_we), 32'(c == 2 || c == 3));
        if (c <= 1) check("R4 overlap rd col", 32'(arr_col), 32'(8'h40 + c));
        if (c == 2 || c == 3) begin
          check("R9 overlap wr col", 32'(arr_col), 32'(8'h80 + c - 2));
          check("R9 overlap wdata", 32'(arr_wdata), 32'(dq_i));
        end
        check("R8 overlap enable", 32'(dq_oe), 32'(c >= 2 && c <= 4));
        check("R7 overlap data", 32'(dq_o),
              (c == 3 || c == 4) ? 32'(word(8'(8'h40 + c - 3))) : 32'd0);
      end
    end
    @(negedge clk);
    cmd = NOP;
    dq_i = '0;
    repeat (4) @(negedge clk);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule